// File: doc/BRIEF.md
# Capture Timer Channel with Interrupt/DMA Steering

This block is a 16-bit up-counting timer with one input-capture channel. The counter starts from a programmable start value and counts up on every clock. When it reaches a programmable wrap limit, it returns to the start value. On a chosen transition of an external input, the channel copies the current count into a capture register and raises an event flag. Two enable bits decide whether that flag shows up as an interrupt, as a DMA request, or not at all. A DMA completion pulse can retire the flag.

A self-test mode lets software exercise the capture path without toggling the pin. While the mode is on, a bus write to the count register loads the written value into the counter and into the capture register in one step, and sets the flag. Counting then carries on from the written value. Software reaches every register over a simple single-cycle register bus. Read data is combinational on the address. A read strobe marks that a read of the channel register has taken place.

Top module: `capt_timer`

## Requirements
- R1: Register addresses are: 0 count, 1 wrap limit, 2 start value, 3 channel control, 4 capture, 5 mode. After reset: count 0x0000, wrap limit 0xFFFF, start value 0x0000, channel control 0, capture 0, mode 0, and `irq` and `dma_req` are low.
- R2: The count increases by one on each clock. In the clock after it equals the wrap limit, it holds the start value.
- R3: With mode bit 0 clear, a write to the count register loads the start value and ignores the written data. It neither sets the flag nor changes the capture register.
- R4: With mode bit 0 set, a write to the count register puts the written value into both the count and the capture register on that clock edge, and sets the flag. The count then increments from that value.
- R5: Channel control bits [4:3] select the pin edge: 00 none, 01 rising, 10 falling, 11 both. The pin passes through two synchroniser stages. The capture register takes the count value present two clock edges after the pin change, and the flag is set on the following edge.
- R6: Channel control bit 1 is the interrupt enable and bit 2 is the DMA enable. `irq` = flag with interrupt enable set and DMA enable clear. `dma_req` = flag with both enables set. Neither output is active otherwise.
- R7: Channel control bit 0 is the flag. Writing 0 to it clears the flag only if a read of the channel register that saw the flag set came before that write, with no other channel write in between. Writing 1 has no effect.
- R8: With the DMA enable set, a high `dma_done` clears the flag. With the DMA enable clear, `dma_done` is ignored.
- R9: A capture event in the same cycle as any clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on address |
| cap_pin | input | 1 | Asynchronous capture input |
| dma_done | input | 1 | DMA transfer completion |
| irq | output | 1 | Channel interrupt |
| dma_req | output | 1 | Channel DMA request |

## Verification
A corrupted count or a wrong wrap compare shows up in the count register on the very next read. It also appears in the capture value, two edges after a pin change. A mis-steered or stuck flag appears on `irq` or `dma_req` in the clock after the event or clear that should have changed it. A faulty arm latch lets a blind write of 0 drop the interrupt at once. Sampling every result one edge after its cause catches off-by-one errors in the synchroniser depth and in the capture timing.

// File: rtl/capt_timer_pkg.sv
// Package: shared constants for the capture timer.
// Assumes a 3-bit register address space with six registers in use.
package capt_timer_pkg;
    localparam int CT_ADDR_W = 3;

    localparam logic [CT_ADDR_W-1:0] A_COUNT = 3'd0;
    localparam logic [CT_ADDR_W-1:0] A_WRAP  = 3'd1;
    localparam logic [CT_ADDR_W-1:0] A_START = 3'd2;
    localparam logic [CT_ADDR_W-1:0] A_CHAN  = 3'd3;
    localparam logic [CT_ADDR_W-1:0] A_CAPT  = 3'd4;
    localparam logic [CT_ADDR_W-1:0] A_MODE  = 3'd5;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    localparam int CHAN_FLAG_BIT = 0;
    localparam int CHAN_IE_BIT   = 1;
    localparam int CHAN_DE_BIT   = 2;
    localparam int CHAN_ES_LSB   = 3;
endpackage

// File: rtl/capt_timer_counter.sv
// Module: up-counter with a programmable start value and wrap limit.
// Assumes a load takes priority over counting. The load puts in either the
// given data (test load) or the start value (plain reload).
module capt_timer_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wrap_val,
    input  logic [W-1:0] start_val,
    input  logic         load_en,
    input  logic         load_data_sel,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] count
);
    // Count register: load, wrap to the start value, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load_en)
            count <= load_data_sel ? load_data : start_val;
        else if (count == wrap_val)
            count <= start_val;
        else
            count <= count + 1'b1;
    end

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && count == wrap_val) |=> count == $past(start_val));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && count != wrap_val) |=> count != $past(count));
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !load_data_sel) |=> count == $past(start_val));
endmodule

// File: rtl/capt_timer_edge.sv
// Module: pin synchroniser and edge detector.
// Assumes the pin is asynchronous. STAGES flops resynchronise it. One more
// flop holds the previous synchronised level for edge detection.
module capt_timer_edge #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] sel,
    output logic       hit
);
    import capt_timer_pkg::*;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              lvl;
    logic              rise;
    logic              fall;

    // First synchroniser stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_sync
        // Each further stage shifts the level along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
        end
    end

    assign lvl = sync_q[STAGES-1];

    // Previous synchronised level, kept for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    // Edge qualification by the selected polarity.
    always_comb begin
        unique case (edge_sel_e'(sel))
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    p_hit_needs_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (lvl != prev_q));
endmodule

// File: rtl/capt_timer_chan.sv
// Module: capture channel with flag, clear arming and interrupt/DMA steering.
// Assumes test loads take priority over pin captures for the capture
// register, and any capture beats any clear for the flag.
module capt_timer_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] count,
    input  logic         pin_hit,
    input  logic         test_hit,
    input  logic [W-1:0] test_data,
    input  logic         ctl_wr,
    input  logic         ctl_rd,
    input  logic [4:0]   ctl_wdata,
    input  logic         dma_done,
    output logic         flag,
    output logic         irq_en,
    output logic         dma_en,
    output logic [1:0]   edge_sel,
    output logic [W-1:0] capt,
    output logic         irq,
    output logic         dma_req
);
    import capt_timer_pkg::*;

    logic armed;
    logic cap_evt;
    logic sw_clr;
    logic hw_clr;

    assign cap_evt = pin_hit | test_hit;
    assign sw_clr  = ctl_wr & ~ctl_wdata[CHAN_FLAG_BIT] & armed;
    assign hw_clr  = dma_done & dma_en;

    // Control fields written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en   <= 1'b0;
            dma_en   <= 1'b0;
            edge_sel <= 2'b00;
        end else if (ctl_wr) begin
            irq_en   <= ctl_wdata[CHAN_IE_BIT];
            dma_en   <= ctl_wdata[CHAN_DE_BIT];
            edge_sel <= ctl_wdata[CHAN_ES_LSB +: 2];
        end
    end

    // Capture register: test load first, else pin capture.
    always_ff @(posedge clk) begin
        if (!rst_n)        capt <= '0;
        else if (test_hit) capt <= test_data;
        else if (pin_hit)  capt <= count;
    end

    // Event flag: set by captures, cleared by an armed write or DMA done.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag <= 1'b0;
        else if (cap_evt)           flag <= 1'b1;
        else if (sw_clr || hw_clr)  flag <= 1'b0;
    end

    // Arm latch: a read that saw the flag set arms; any write or clear disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)                          armed <= 1'b0;
        else if (ctl_wr || (hw_clr && !cap_evt)) armed <= 1'b0;
        else if (ctl_rd && flag)             armed <= 1'b1;
    end

    assign irq     = flag & irq_en & ~dma_en;
    assign dma_req = flag & irq_en & dma_en;

    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && dma_req));
    p_test_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        test_hit |=> (flag && capt == $past(test_data)));
    p_no_blind_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !armed && !(dma_done && dma_en)) |=> flag);
    p_capture_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> flag);
    p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(cap_evt));
    p_done_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !dma_en && !ctl_wr) |=> flag);
endmodule

// File: rtl/capt_timer.sv
// Module: top of the capture timer. It holds the wrap, start and mode
// registers, decodes the register bus and wires counter, edge detector and
// channel together. Assumes single-cycle bus strobes and combinational reads.
module capt_timer #(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   bus_addr,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         cap_pin,
    input  logic         dma_done,
    output logic         irq,
    output logic         dma_req
);
    import capt_timer_pkg::*;

    localparam logic [W-1:0] WRAP_RST = {W{1'b1}};

    logic [W-1:0] wrap_q;
    logic [W-1:0] start_q;
    logic         test_mode;
    logic [W-1:0] count;
    logic [W-1:0] capt;
    logic         cnt_wr;
    logic         test_hit;
    logic         pin_hit;
    logic         flag;
    logic         irq_en;
    logic         dma_en;
    logic [1:0]   edge_sel;

    assign cnt_wr   = bus_wr && (bus_addr == A_COUNT);
    assign test_hit = cnt_wr && test_mode;

    // Configuration registers: wrap limit, start value and test mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_q    <= WRAP_RST;
            start_q   <= '0;
            test_mode <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == A_WRAP)  wrap_q    <= bus_wdata;
            if (bus_addr == A_START) start_q   <= bus_wdata;
            if (bus_addr == A_MODE)  test_mode <= bus_wdata[0];
        end
    end

    capt_timer_counter #(.W(W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .wrap_val      (wrap_q),
        .start_val     (start_q),
        .load_en       (cnt_wr),
        .load_data_sel (test_mode),
        .load_data     (bus_wdata),
        .count         (count)
    );

    capt_timer_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cap_pin),
        .sel   (edge_sel),
        .hit   (pin_hit)
    );

    capt_timer_chan #(.W(W)) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (count),
        .pin_hit   (pin_hit),
        .test_hit  (test_hit),
        .test_data (bus_wdata),
        .ctl_wr    (bus_wr && (bus_addr == A_CHAN)),
        .ctl_rd    (bus_rd && (bus_addr == A_CHAN)),
        .ctl_wdata (bus_wdata[4:0]),
        .dma_done  (dma_done),
        .flag      (flag),
        .irq_en    (irq_en),
        .dma_en    (dma_en),
        .edge_sel  (edge_sel),
        .capt      (capt),
        .irq       (irq),
        .dma_req   (dma_req)
    );

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_COUNT: bus_rdata = count;
            A_WRAP:  bus_rdata = wrap_q;
            A_START: bus_rdata = start_q;
            A_CHAN:  bus_rdata[4:0] = {edge_sel, dma_en, irq_en, flag};
            A_CAPT:  bus_rdata = capt;
            A_MODE:  bus_rdata[0] = test_mode;
            default: bus_rdata = '0;
        endcase
    end

    p_test_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        test_hit |=> count == $past(bus_wdata));
endmodule

// File: tb/tb_capt_timer.sv
module tb_capt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cap_pin = 1'b0;
    logic        dma_done = 1'b0;
    logic        irq;
    logic        dma_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    capt_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_pin(cap_pin), .dma_done(dma_done), .irq(irq), .dma_req(dma_req)
    );

    // Steering vectors: {dma_en, irq_en, expected irq, expected dma_req}
    localparam logic [3:0] STEER [4] = '{4'b0000, 4'b0110, 4'b1000, 4'b1101};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic clear_flag(input logic [15:0] ctl);
        logic [15:0] v;
        rd(3'd3, v);
        wr(3'd3, ctl & 16'hFFFE);
    endtask

    task automatic pulse_done();
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R1: count value while reset is held
        bus_addr = 3'd0; #1 check("R1 count", bus_rdata, 16'h0000);
        check("R1 irq", {15'b0, irq}, 16'h0);
        check("R1 dma_req", {15'b0, dma_req}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rd(3'd1, v); check("R1 wrap", v, 16'hFFFF);
        rd(3'd2, v); check("R1 start", v, 16'h0000);
        rd(3'd3, v); check("R1 chan", v, 16'h0000);
        rd(3'd4, v); check("R1 capt", v, 16'h0000);
        rd(3'd5, v); check("R1 mode", v, 16'h0000);

        // R4: test-mode count write
        wr(3'd5, 16'h0001);
        wr(3'd0, 16'h78AC);
        rd(3'd0, v); check("R4 count loaded", v, 16'h78AC);
        rd(3'd0, v); check("R4 count continues", v, 16'h78AD);
        rd(3'd4, v); check("R4 capture", v, 16'h78AC);
        rd(3'd3, v); check("R4 flag", v & 16'h1, 16'h0001);
        wr(3'd3, 16'h0000);
        rd(3'd3, v); check("R7 armed clear", v & 16'h1, 16'h0000);

        // R3: plain count write reloads start value
        wr(3'd5, 16'h0000);
        wr(3'd2, 16'h0100);
        wr(3'd0, 16'h1234);
        rd(3'd0, v); check("R3 reload", v, 16'h0100);
        rd(3'd3, v); check("R3 no flag", v & 16'h1, 16'h0000);
        rd(3'd4, v); check("R3 capture kept", v, 16'h78AC);

        // R2: wrap at limit
        wr(3'd1, 16'h0105);
        wr(3'd0, 16'h0000);
        repeat (5) @(negedge clk);
        rd(3'd0, v); check("R2 at limit", v, 16'h0105);
        rd(3'd0, v); check("R2 wrapped", v, 16'h0100);
        wr(3'd1, 16'hFFFF);

        // R5: rising edge capture timing
        wr(3'd3, 16'h000A);
        wr(3'd0, 16'h0000);
        cap_pin = 1'b1;
        repeat (3) @(negedge clk);
        rd(3'd4, v); check("R5 rise capture", v, 16'h0102);
        check("R5 rise irq", {15'b0, irq}, 16'h1);

        // R5: falling only
        clear_flag(16'h0012);
        cap_pin = 1'b0;
        repeat (4) @(negedge clk);
        check("R5 fall irq", {15'b0, irq}, 16'h1);
        clear_flag(16'h0012);
        cap_pin = 1'b1;
        repeat (4) @(negedge clk);
        check("R5 rise ignored", {15'b0, irq}, 16'h0);
        // R5: both edges, then none
        wr(3'd3, 16'h001A);
        cap_pin = 1'b0;
        repeat (4) @(negedge clk);
        check("R5 both irq", {15'b0, irq}, 16'h1);
        clear_flag(16'h0002);
        cap_pin = 1'b1;
        repeat (4) @(negedge clk);
        check("R5 none ignored", {15'b0, irq}, 16'h0);

        // R6: steering table
        wr(3'd5, 16'h0001);
        for (int i = 0; i < 4; i++) begin
            logic [15:0] ctl;
            ctl = {13'b0, STEER[i][3], STEER[i][2], 1'b0};
            clear_flag(ctl);
            wr(3'd0, 16'h0300 + 16'(i));
            check("R6 irq", {15'b0, irq}, {15'b0, STEER[i][1]});
            check("R6 dma_req", {15'b0, dma_req}, {15'b0, STEER[i][0]});
        end

        // R7: blind write of 0 ignored, armed write clears, write 1 ignored
        wr(3'd3, 16'h0002);
        wr(3'd0, 16'h0400);
        wr(3'd3, 16'h0002);
        check("R7 blind clear ignored", {15'b0, irq}, 16'h1);
        rd(3'd3, v); check("R7 read sees flag", v & 16'h1, 16'h1);
        wr(3'd3, 16'h0002);
        check("R7 armed clear", {15'b0, irq}, 16'h0);
        wr(3'd3, 16'h0003);
        check("R7 write one ignored", {15'b0, irq}, 16'h0);

        // R8: DMA done clears only when DMA enabled
        wr(3'd3, 16'h0006);
        wr(3'd0, 16'h0500);
        check("R8 dma_req set", {15'b0, dma_req}, 16'h1);
        pulse_done();
        check("R8 done clears", {15'b0, dma_req}, 16'h0);
        wr(3'd3, 16'h0002);
        wr(3'd0, 16'h0501);
        pulse_done();
        check("R8 done ignored", {15'b0, irq}, 16'h1);

        // R9: capture in same cycle as DMA done keeps the flag
        clear_flag(16'h0006);
        wr(3'd0, 16'h0600);
        dma_done = 1'b1;
        wr(3'd0, 16'h0601);
        dma_done = 1'b0;
        check("R9 capture wins", {15'b0, dma_req}, 16'h1);
        rd(3'd4, v); check("R9 capture value", v, 16'h0601);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule